// File: doc/BRIEF.md
# Dual Estimated-Path FIR Engine

This block evaluates two fixed acoustic path models against a single stream of reference samples. Each time a new sample is presented with a start strobe, the sample is pushed into a shared 64-entry history. One sequential multiply-accumulate datapath then forms two 64-tap dot products over that history. The first uses the primary-path coefficient set and yields the estimated disturbance at the ear. The second uses the secondary-path coefficient set and yields the filtered reference that an adaptive canceller needs for its weight update.

Both coefficient sets are constant tables built when the design is elaborated. Samples and coefficients are 16-bit two's complement in Q15. The two sums run back to back on the one multiplier, each in its own wide accumulator. When both sums are complete, both results are rounded, saturated to 16 bits and registered together, and a one-cycle done pulse is raised. A new sample cycle costs 129 clocks plus one idle cycle, which is far inside a per-sample budget of about a thousand clocks.

Top module: `dual_path_fir`

## Requirements
- R1: Reset drives both outputs and done to 0 and clears the whole sample history. The first sample after reset therefore sees zeros in all older taps.
- R2: The primary result is the rounded, saturated Q15 value of sum over m=0..63 of p_m*x(n-m), where x(n) is the newest sample. The coefficients are p_0 = 32767, and for m>=1 p_m is the low 16 bits of (1237*m + 501) read as signed.
- R3: The secondary result is the rounded, saturated Q15 value of sum over m=0..63 of s_m*x(n-m). The coefficients are s_0 = -32768, and for m>=1 s_m is the low 16 bits of (2711*m + 97) read as signed.
- R4: An output equals floor((acc + 16384) / 32768), where acc is the exact sum of products, clamped to the range -32768..32767.
- R5: The edge that accepts start is counted as edge 0. Done is high for exactly one cycle, from edge 129 to edge 130, and it rises exactly once per accepted start.
- R6: Both outputs change only at the edge that raises done, and they hold their values in every other cycle.
- R7: A start that arrives while a computation is in progress is ignored. It does not enter the history, it does not shift it, and it does not alter the result in flight. Start is accepted again in the cycle in which done is high.
- R8: The history keeps exactly the 64 newest samples. A sample stops contributing once 64 newer samples have been accepted.
- R9: The accumulators hold the exact sum of 64 full-scale products without wrapping, so an all-full-scale history still produces the exact rounded and saturated result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Strobe that accepts sample_in when the block is idle |
| sample_in | input | 16 | New reference sample, Q15 two's complement |
| primary_out | output | 16 | Primary-path estimate, Q15 |
| secondary_out | output | 16 | Secondary-path filtered reference, Q15 |
| done | output | 1 | One-cycle pulse when both outputs are updated |

## Verification
Both results fall due together, 129 clock edges after the edge that accepts start. The bench drives start at a falling edge and then counts falling edges until done appears. It requires that count to be exactly 129, reads both outputs in that same half-cycle, and checks that done has dropped one cycle later. Midway through a run it samples the outputs again to confirm they still hold the previous results. In some runs it also issues a stray start, whose absence from the history shows up only in the following sample's results. A checker module ties done to a cycle counter started at each accepted start, and it also checks that the write pointer moves only on accepted starts.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } dpf_state_e;

  // Coefficient of tap m for path 0 (primary) or path 1 (secondary), w bits signed.
  function automatic longint coef_gen(input int path, input int m, input int w);
    longint full;
    longint half;
    longint v;
    full = longint'(1) << w;
    half = full >> 1;
    if (m == 0) begin
      v = (path == 0) ? (half - 1) : (-half);
    end else begin
      v = (path == 0) ? (longint'(m) * 1237 + 501) : (longint'(m) * 2711 + 97);
      v = v % full;
      if (v >= half) v = v - full;
    end
    return v;
  endfunction

  // Round half up at bit position frac, then clamp to ow signed bits.
  function automatic longint round_sat(input longint acc, input int frac, input int ow);
    longint r;
    longint hi;
    longint lo;
    r  = (acc + (longint'(1) <<< (frac - 1))) >>> frac;
    hi = (longint'(1) <<< (ow - 1)) - 1;
    lo = -(longint'(1) <<< (ow - 1));
    if (r > hi) r = hi;
    else if (r < lo) r = lo;
    return r;
  endfunction

endpackage

// File: rtl/dpf_history.sv
module dpf_history #(
  parameter int DEPTH = 64,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic signed [DW-1:0] wr_data,
  input  logic [AW-1:0]        rd_lag,
  output logic signed [DW-1:0] rd_data,
  output logic [AW-1:0]        wr_ptr
);

  logic signed [DW-1:0] mem [DEPTH];
  logic [AW-1:0]        head_q;
  logic [AW-1:0]        ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      head_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[ptr_q] <= wr_data;
      head_q     <= ptr_q;
      ptr_q      <= ptr_q + 1'b1;
    end
  end

  // Lag 0 is the newest sample; the index wraps modulo DEPTH.
  assign rd_data = mem[head_q - rd_lag];
  assign wr_ptr  = ptr_q;

endmodule

// File: rtl/dpf_coef_rom.sv
module dpf_coef_rom #(
  parameter int PATH = 0,
  parameter int TAPS = 64,
  parameter int CW   = 16,
  localparam int AW  = $clog2(TAPS)
) (
  input  logic [AW-1:0]        addr,
  output logic signed [CW-1:0] coef
);

  logic signed [CW-1:0] rom [TAPS];

  for (genvar i = 0; i < TAPS; i++) begin : g_entry
    assign rom[i] = CW'(dpf_pkg::coef_gen(PATH, i, CW));
  end

  assign coef = rom[addr];

endmodule

// File: rtl/dpf_mac.sv
module dpf_mac #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int NPATH = 2,
  parameter int ACC_W = 38,
  localparam int PW   = DW + CW,
  localparam int SW   = (NPATH > 1) ? $clog2(NPATH) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clear,
  input  logic                          en,
  input  logic [SW-1:0]                 sel,
  input  logic signed [DW-1:0]          a,
  input  logic signed [CW-1:0]          b,
  output logic [NPATH-1:0][ACC_W-1:0]   acc
);

  logic signed [PW-1:0] prod;

  assign prod = PW'(a) * PW'(b);

  for (genvar p = 0; p < NPATH; p++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst || clear) acc[p] <= '0;
      else if (en && (sel == SW'(p))) acc[p] <= acc[p] + ACC_W'(prod);
    end
  end

endmodule

// File: rtl/dpf_seq.sv
module dpf_seq #(
  parameter int TAPS  = 64,
  parameter int NPATH = 2,
  localparam int AW   = $clog2(TAPS),
  localparam int SW   = (NPATH > 1) ? $clog2(NPATH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          accept,
  output logic          busy,
  output logic          mac_en,
  output logic          finish,
  output logic [AW-1:0] tap,
  output logic [SW-1:0] sel
);

  dpf_pkg::dpf_state_e state_q;

  assign busy   = (state_q != dpf_pkg::ST_IDLE);
  assign accept = start && !busy;
  assign mac_en = (state_q == dpf_pkg::ST_RUN);
  assign finish = (state_q == dpf_pkg::ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= dpf_pkg::ST_IDLE;
      tap     <= '0;
      sel     <= '0;
    end else begin
      unique case (state_q)
        dpf_pkg::ST_IDLE: begin
          if (start) begin
            state_q <= dpf_pkg::ST_RUN;
            tap     <= '0;
            sel     <= '0;
          end
        end
        dpf_pkg::ST_RUN: begin
          if (tap == AW'(TAPS - 1)) begin
            tap <= '0;
            if (sel == SW'(NPATH - 1)) state_q <= dpf_pkg::ST_FIN;
            else sel <= sel + 1'b1;
          end else begin
            tap <= tap + 1'b1;
          end
        end
        default: state_q <= dpf_pkg::ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dual_path_fir.sv
module dual_path_fir #(
  parameter int TAPS   = 64,
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int FRAC   = 15,
  localparam int NPATH = 2,
  localparam int AW    = $clog2(TAPS),
  localparam int SW    = $clog2(NPATH),
  localparam int ACC_W = DW + CW + AW,
  localparam int LAT   = NPATH * TAPS + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic signed [DW-1:0] sample_in,
  output logic signed [DW-1:0] primary_out,
  output logic signed [DW-1:0] secondary_out,
  output logic                 done
);

  // Named internal events, also observed by the bound checker.
  logic                        accept_w;
  logic                        busy_w;
  logic                        mac_en_w;
  logic                        finish_w;
  logic [AW-1:0]               tap_w;
  logic [SW-1:0]               sel_w;
  logic [AW-1:0]               wr_ptr_w;
  logic signed [DW-1:0]        hist_w;
  logic signed [CW-1:0]        coef_v [NPATH];
  logic signed [CW-1:0]        coef_w;
  logic [NPATH-1:0][ACC_W-1:0] acc_w;

  dpf_seq #(.TAPS(TAPS), .NPATH(NPATH)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .accept (accept_w),
    .busy   (busy_w),
    .mac_en (mac_en_w),
    .finish (finish_w),
    .tap    (tap_w),
    .sel    (sel_w)
  );

  dpf_history #(.DEPTH(TAPS), .DW(DW)) u_hist (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (accept_w),
    .wr_data (sample_in),
    .rd_lag  (tap_w),
    .rd_data (hist_w),
    .wr_ptr  (wr_ptr_w)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_rom
    dpf_coef_rom #(.PATH(p), .TAPS(TAPS), .CW(CW)) u_rom (
      .addr (tap_w),
      .coef (coef_v[p])
    );
  end

  assign coef_w = coef_v[sel_w];

  dpf_mac #(.DW(DW), .CW(CW), .NPATH(NPATH), .ACC_W(ACC_W)) u_mac (
    .clk   (clk),
    .rst   (rst),
    .clear (accept_w),
    .en    (mac_en_w),
    .sel   (sel_w),
    .a     (hist_w),
    .b     (coef_w),
    .acc   (acc_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      primary_out   <= '0;
      secondary_out <= '0;
      done          <= 1'b0;
    end else begin
      done <= finish_w;
      if (finish_w) begin
        primary_out   <= DW'(dpf_pkg::round_sat(longint'($signed(acc_w[0])), FRAC, DW));
        secondary_out <= DW'(dpf_pkg::round_sat(longint'($signed(acc_w[1])), FRAC, DW));
      end
    end
  end

endmodule

// File: rtl/dpf_checker.sv
module dpf_checker #(
  parameter int AW  = 6,
  parameter int DW  = 16,
  parameter int LAT = 129,
  localparam int CNT_W = $clog2(LAT + 2) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic          busy,
  input logic          accept,
  input logic [AW-1:0] wr_ptr,
  input logic [DW-1:0] primary_out,
  input logic [DW-1:0] secondary_out
);

  logic [CNT_W-1:0] cyc_q;

  always_ff @(posedge clk) begin
    if (rst) cyc_q <= '0;
    else if (accept) cyc_q <= CNT_W'(1);
    else if (done) cyc_q <= '0;
    else if (cyc_q != '0) cyc_q <= cyc_q + 1'b1;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R5
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst) done |-> (cyc_q == CNT_W'(LAT + 1))); // R5
  AST_DONE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst) (cyc_q == '0) |-> !done); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> $stable({primary_out, secondary_out})); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst) (busy && start) |=> $stable(wr_ptr)); // R7
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst) accept |=> (wr_ptr == $past(wr_ptr) + 1'b1)); // R8
  AST_PTR_QUIET: assert property (@(posedge clk) disable iff (rst) !accept |=> $stable(wr_ptr)); // R8

endmodule

bind dual_path_fir dpf_checker #(.AW(AW), .DW(DW), .LAT(LAT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .done          (done),
  .busy          (busy_w),
  .accept        (accept_w),
  .wr_ptr        (wr_ptr_w),
  .primary_out   (primary_out),
  .secondary_out (secondary_out)
);

// File: tb/sim_dual_path_fir.sv
module sim_dual_path_fir;

  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 64;
  localparam int LAT  = 2 * TAPS + 1;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start = 1'b0;
  logic signed [15:0] sample_in = '0;
  logic signed [15:0] primary_out;
  logic signed [15:0] secondary_out;
  logic               done;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  longint hist [TAPS];
  longint prev_p = 0;
  longint prev_s = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_path_fir u0 (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .sample_in     (sample_in),
    .primary_out   (primary_out),
    .secondary_out (secondary_out),
    .done          (done)
  );

  // Coefficient tables restated from R2 and R3.
  function automatic longint ref_coef(input int path, input int m);
    longint v;
    if (m == 0) return (path == 0) ? 32767 : -32768;
    v = (path == 0) ? (1237 * m + 501) : (2711 * m + 97);
    v = v - 65536 * (v / 65536);
    if (v > 32767) v = v - 65536;
    return v;
  endfunction

  // Rounding and clamping restated from R4 with floor division.
  function automatic longint ref_out(input longint acc);
    longint t;
    longint md;
    t  = acc + 16384;
    md = ((t % 32768) + 32768) % 32768;
    t  = (t - md) / 32768;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t;
  endfunction

  function automatic longint ref_sum(input int path);
    longint s = 0;
    for (int m = 0; m < TAPS; m++) s += ref_coef(path, m) * hist[m];
    return s;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < TAPS; i++) hist[i] = 0;
    prev_p = 0;
    prev_s = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clear_model();
    check("R1 primary after reset", primary_out, 0);
    check("R1 secondary after reset", secondary_out, 0);
    check("R1 done after reset", done, 0);
  endtask

  // Push one sample; poke issues a stray start while busy (R7).
  task automatic push(input longint x, input bit poke, input string tag);
    int k;
    longint ep;
    longint es;
    @(negedge clk);
    sample_in = 16'(x);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sample_in = 16'(~x);
    k = 0;
    while (!done && k < LAT + 10) begin
      start = (poke && k == 50);
      if (k == 60) begin
        check("R6 primary holds while busy", primary_out, prev_p);
        check("R6 secondary holds while busy", secondary_out, prev_s);
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i - 1];
    hist[0] = x;
    ep = ref_out(ref_sum(0));
    es = ref_out(ref_sum(1));
    check({"R5 latency ", tag}, k, LAT);
    check({"R2 primary ", tag}, primary_out, ep);
    check({"R3 secondary ", tag}, secondary_out, es);
    prev_p = ep;
    prev_s = es;
    @(negedge clk);
    check({"R5 done single pulse ", tag}, done, 0);
  endtask

  initial begin
    int lfsr;
    do_reset();

    // R1/R4: impulse of -32768 after reset saturates the secondary result.
    push(-32768, 1'b0, "R1 impulse");
    check("R4 secondary saturates high", secondary_out, 32767);
    check("R4 primary rounded", primary_out, -32767);

    // R8: walk the impulse through all taps and out of the history.
    for (int i = 1; i < TAPS + 3; i++) push(0, (i % 16) == 3, "R8 walk");
    check("R8 impulse gone primary", primary_out, 0);
    check("R8 impulse gone secondary", secondary_out, 0);

    // R9: full-scale histories of both signs.
    for (int i = 0; i < TAPS; i++) push(32767, 1'b0, "R9 plus");
    for (int i = 0; i < TAPS; i++) push(-32768, 1'b0, "R9 minus");

    // R7: mixed data with stray starts mid-run.
    lfsr = 32'h1ACE;
    for (int i = 0; i < 40; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      push(longint'(lfsr) - 32768, (i % 3) == 0, "R7 mixed");
    end

    // R1: reset mid-stream clears the history.
    do_reset();
    push(12345, 1'b0, "R1 after second reset");
    push(-7, 1'b1, "R7 after reset");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule